// File: doc/BRIEF.md
# Security Lock Controller

This block keeps a lock bit and a 64-bit encryption key for a secure processing subsystem. It also runs the erase sequence that follows whenever the lock is released. A boot-time loader talks to it with short commands: lock, unlock and fresh key. An external tamper sensor drives a self-destruct line, and a free-running random source supplies key material one byte at a time. The block's outputs are the key itself, a strobe that wipes a 48-byte vector RAM, a write stream that zeroes the bottom 32 kB of external memory, and a permit signal that gates the loader's memory accesses.

Loader commands take effect only in loader mode. The block enters that mode once the program pin has stayed low for a parameterised number of consecutive clocks, and leaves it once the pin has stayed high for the same number. The self-destruct line does not depend on loader mode. It passes through a deglitch filter: short pulses are dropped, and long pulses start the same erase as an unlock command. Once the erase has begun it cannot be stopped. The key and the vector RAM are wiped first, then the memory is zero-filled at one write per clock, and finally a new key is gathered from the random source.

Top module: `seclock_ctrl`

## Requirements
- R1: After reset, `locked`, `busy`, `vec_erase` and `fill_we` are 0, `key` is zero, and `mem_grant` is 0 even when `mem_req` is high, because loader mode is off.
- R2: Loader mode begins after `prog_n` has been low for 48 consecutive clocks and ends after it has been high for 48. A low or high spell shorter than about 40 clocks leaves the mode unchanged.
- R3: Command code 2'b01 (lock) sets `locked` when loader mode is on and the block is idle. Outside loader mode, every command (lock 2'b01, unlock 2'b10, fresh key 2'b11) is ignored.
- R4: While `locked` is 1, `mem_grant` stays 0. While unlocked, idle and in loader mode, `mem_grant` follows `mem_req` in the same cycle.
- R5: Command 2'b10 (unlock) in loader mode is accepted regardless of the lock state. In the cycle after it is sampled, `locked` is 0, `key` is zero, `busy` is 1 and `vec_erase` is high. `vec_erase` stays high for exactly one cycle.
- R6: The zero-fill begins in the cycle after the `vec_erase` pulse. It raises `fill_we` for 32768 consecutive cycles with `fill_addr` stepping by one from 0x0000 to 0x7FFF, and then `fill_we` drops.
- R7: After the last fill write, one idle cycle passes. The key then takes `rng_byte` on each of the next 8 clock edges, shifting left, so the first byte taken ends up in bits 63:56. `busy` falls when the eighth byte has been taken.
- R8: Command 2'b11 (fresh key), sent while unlocked, idle and in loader mode, loads a key from the 8 `rng_byte` values on the 8 edges after the command edge. While locked, the command leaves `key` unchanged and `busy` low. Apart from these loads, `key` changes only when it is wiped.
- R9: A high pulse on `sdi` lasting at least 60 clocks starts the R5–R7 sequence, whether or not loader mode is on. Pulses of 20 clocks or fewer have no effect.
- R10: While `busy` is high, lock, unlock and fresh-key commands are ignored. The sequence runs to completion and `locked` stays 0 throughout.
- R11: `mem_grant` is 0 in every cycle in which `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_n | input | 1 | Program pin, low requests loader mode |
| sdi | input | 1 | Self-destruct request, active high, asynchronous |
| cmd_valid | input | 1 | Loader command strobe |
| cmd_op | input | 2 | Command code: 01 lock, 10 unlock, 11 fresh key |
| rng_byte | input | 8 | Random byte source |
| mem_req | input | 1 | Loader asks for an external memory access |
| mem_grant | output | 1 | External memory access permitted |
| locked | output | 1 | Security lock state |
| busy | output | 1 | Erase or key-load sequence in progress |
| key | output | 64 | Current encryption key |
| vec_erase | output | 1 | One-cycle wipe strobe for the vector RAM |
| fill_we | output | 1 | Zero-fill write enable |
| fill_addr | output | 15 | Zero-fill write address |

## Verification
Several properties are checked on every cycle. The fill address must step by one and start at zero, and the wipe strobe must lead straight into the fill. Busy must never coincide with the lock. A grant may never appear while locked or busy. The wipe strobe must always see a zero key and an open lock, the key must hold still outside a sequence, and the filter and mode tracker must never produce a spurious edge. Other behaviour shows only through the bench's scenarios: the exact mode-entry and pulse-length thresholds, the order in which random bytes land in the key, the full fill address sweep, and the fact that commands injected partway through an erase are dropped.

// File: rtl/seclock_pkg.sv
package seclock_pkg;

    typedef enum logic [1:0] {
        CMD_NONE   = 2'b00,
        CMD_LOCK   = 2'b01,
        CMD_UNLOCK = 2'b10,
        CMD_NEWKEY = 2'b11
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WIPE,
        ST_FILL,
        ST_KEYGEN
    } seq_e;

    typedef struct packed {
        logic valid;
        cmd_e op;
    } cmd_t;

    localparam int DEF_KEY_BYTES = 8;
    localparam int DEF_FILL_AW   = 15;
    localparam int DEF_PROG_HOLD = 48;
    localparam int DEF_REJECT    = 20;
    localparam int DEF_ACCEPT    = 60;

    function automatic logic cmd_is(cmd_t c, cmd_e op);
        return c.valid && (c.op == op);
    endfunction

    function automatic int trig_len(int reject_cyc, int accept_cyc);
        return reject_cyc + (accept_cyc - reject_cyc + 1) / 2;
    endfunction

endpackage

// File: rtl/sl_progmode.sv
module sl_progmode #(
    parameter int HOLD_CYC = seclock_pkg::DEF_PROG_HOLD
) (
    input  logic clk,
    input  logic rst,
    input  logic prog_n,
    output logic ldr_mode
);
    localparam int HW = $clog2(HOLD_CYC + 1);

    logic [1:0]    sync_q;
    logic [HW-1:0] cnt_q;
    logic          mode_q;

    // Counting runs while the pin level disagrees with the current mode.
    // Pin low means loader mode is wanted, so pin == mode means disagreement.
    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 2'b11;
            cnt_q  <= '0;
            mode_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], prog_n};
            if (sync_q[1] == mode_q) begin
                if (cnt_q == HW'(HOLD_CYC - 1)) begin
                    mode_q <= ~mode_q;
                    cnt_q  <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                cnt_q <= '0;
            end
        end
    end

    assign ldr_mode = mode_q;

    a_r2_enter_on_low: assert property (@(posedge clk) disable iff (rst)
        $rose(mode_q) |-> !$past(sync_q[1]));

    a_r2_leave_on_high: assert property (@(posedge clk) disable iff (rst)
        $fell(mode_q) |-> $past(sync_q[1]));

endmodule

// File: rtl/sl_deglitch.sv
module sl_deglitch #(
    parameter int REJECT_CYC = seclock_pkg::DEF_REJECT,
    parameter int ACCEPT_CYC = seclock_pkg::DEF_ACCEPT
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_in,
    output logic fire
);
    localparam int TRIG = seclock_pkg::trig_len(REJECT_CYC, ACCEPT_CYC);
    localparam int CW   = $clog2(TRIG + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;
    logic          fire_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 2'b00;
            cnt_q  <= '0;
            fire_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], raw_in};
            fire_q <= sync_q[1] && (cnt_q == CW'(TRIG - 1));
            if (!sync_q[1]) begin
                cnt_q <= '0;
            end else if (cnt_q != CW'(TRIG)) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign fire = fire_q;

    a_r9_single_fire: assert property (@(posedge clk) disable iff (rst)
        fire_q |=> !fire_q);

    a_r9_fire_needs_level: assert property (@(posedge clk) disable iff (rst)
        fire_q |-> $past(sync_q[1]));

endmodule

// File: rtl/sl_wipe_seq.sv
module sl_wipe_seq #(
    parameter int FILL_AW   = seclock_pkg::DEF_FILL_AW,
    parameter int KEY_BYTES = seclock_pkg::DEF_KEY_BYTES
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start_wipe,
    input  logic                   start_keygen,
    input  logic [7:0]             rng_byte,
    output logic                   busy,
    output logic                   wipe_pulse,
    output logic                   fill_we,
    output logic [FILL_AW-1:0]     fill_addr,
    output logic [KEY_BYTES*8-1:0] key_q
);
    import seclock_pkg::*;

    localparam int KW  = KEY_BYTES * 8;
    localparam int KCW = (KEY_BYTES > 1) ? $clog2(KEY_BYTES) : 1;

    seq_e               st_q;
    logic [FILL_AW-1:0] addr_q;
    logic [KCW-1:0]     kcnt_q;
    logic [KW-1:0]      key_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            addr_q <= '0;
            kcnt_q <= '0;
            key_r  <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (start_wipe) begin
                        st_q  <= ST_WIPE;
                        key_r <= '0;
                    end else if (start_keygen) begin
                        st_q   <= ST_KEYGEN;
                        kcnt_q <= '0;
                    end
                end
                ST_WIPE: begin
                    st_q   <= ST_FILL;
                    addr_q <= '0;
                end
                ST_FILL: begin
                    addr_q <= addr_q + 1'b1;
                    if (addr_q == {FILL_AW{1'b1}}) begin
                        st_q   <= ST_KEYGEN;
                        kcnt_q <= '0;
                    end
                end
                ST_KEYGEN: begin
                    key_r  <= {key_r[KW-9:0], rng_byte};
                    kcnt_q <= kcnt_q + 1'b1;
                    if (kcnt_q == KCW'(KEY_BYTES - 1)) begin
                        st_q <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy       = (st_q != ST_IDLE);
    assign wipe_pulse = (st_q == ST_WIPE);
    assign fill_we    = (st_q == ST_FILL);
    assign fill_addr  = addr_q;
    assign key_q      = key_r;

    a_r6_addr_step: assert property (@(posedge clk) disable iff (rst)
        fill_we && $past(fill_we) |-> fill_addr == FILL_AW'($past(fill_addr) + 1'b1));

    a_r6_fill_from_zero: assert property (@(posedge clk) disable iff (rst)
        $rose(fill_we) |-> fill_addr == '0);

    a_r5_wipe_then_fill: assert property (@(posedge clk) disable iff (rst)
        wipe_pulse |=> fill_we);

    a_r8_key_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy && $past(!busy) |-> $stable(key_q));

endmodule

// File: rtl/seclock_ctrl.sv
module seclock_ctrl #(
    parameter int PROG_HOLD  = seclock_pkg::DEF_PROG_HOLD,
    parameter int REJECT_CYC = seclock_pkg::DEF_REJECT,
    parameter int ACCEPT_CYC = seclock_pkg::DEF_ACCEPT,
    parameter int FILL_AW    = seclock_pkg::DEF_FILL_AW,
    parameter int KEY_BYTES  = seclock_pkg::DEF_KEY_BYTES
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   prog_n,
    input  logic                   sdi,
    input  logic                   cmd_valid,
    input  logic [1:0]             cmd_op,
    input  logic [7:0]             rng_byte,
    input  logic                   mem_req,
    output logic                   mem_grant,
    output logic                   locked,
    output logic                   busy,
    output logic [KEY_BYTES*8-1:0] key,
    output logic                   vec_erase,
    output logic                   fill_we,
    output logic [FILL_AW-1:0]     fill_addr
);
    import seclock_pkg::*;

    logic ldr_mode;
    logic sdi_fire;
    logic lock_q;
    logic start_wipe;
    logic start_keygen;
    logic take_lock;
    cmd_t cmd;

    assign cmd.valid = cmd_valid;
    assign cmd.op    = cmd_e'(cmd_op);

    sl_progmode #(.HOLD_CYC(PROG_HOLD)) u_mode (
        .clk      (clk),
        .rst      (rst),
        .prog_n   (prog_n),
        .ldr_mode (ldr_mode)
    );

    sl_deglitch #(.REJECT_CYC(REJECT_CYC), .ACCEPT_CYC(ACCEPT_CYC)) u_filt (
        .clk    (clk),
        .rst    (rst),
        .raw_in (sdi),
        .fire   (sdi_fire)
    );

    // Tamper and unlock both start the wipe; nothing starts while busy.
    assign start_wipe   = !busy && (sdi_fire || (ldr_mode && cmd_is(cmd, CMD_UNLOCK)));
    assign start_keygen = !busy && ldr_mode && !lock_q && cmd_is(cmd, CMD_NEWKEY);
    assign take_lock    = !busy && ldr_mode && cmd_is(cmd, CMD_LOCK);

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= 1'b0;
        end else if (start_wipe) begin
            lock_q <= 1'b0;
        end else if (take_lock) begin
            lock_q <= 1'b1;
        end
    end

    sl_wipe_seq #(.FILL_AW(FILL_AW), .KEY_BYTES(KEY_BYTES)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .start_wipe   (start_wipe),
        .start_keygen (start_keygen),
        .rng_byte     (rng_byte),
        .busy         (busy),
        .wipe_pulse   (vec_erase),
        .fill_we      (fill_we),
        .fill_addr    (fill_addr),
        .key_q        (key)
    );

    assign locked    = lock_q;
    assign mem_grant = mem_req && ldr_mode && !lock_q && !busy;

    a_r10_busy_unlocked: assert property (@(posedge clk) disable iff (rst)
        busy |-> !locked);

    a_r4_no_grant_locked: assert property (@(posedge clk) disable iff (rst)
        mem_grant |-> !locked);

    a_r11_no_grant_busy: assert property (@(posedge clk) disable iff (rst)
        mem_grant |-> !busy);

    a_r5_erase_clean: assert property (@(posedge clk) disable iff (rst)
        vec_erase |-> (key == '0) && !locked);

endmodule

// File: tb/sim_seclock_ctrl.sv
module sim_seclock_ctrl;
    localparam int FILL_N = 32768;

    logic        clk = 1'b0;
    logic        rst;
    logic        prog_n, sdi, cmd_valid, mem_req;
    logic [1:0]  cmd_op;
    logic [7:0]  rng_byte;
    logic        mem_grant, locked, busy, vec_erase, fill_we;
    logic [63:0] key;
    logic [14:0] fill_addr;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    seclock_ctrl u0 (
        .clk(clk), .rst(rst), .prog_n(prog_n), .sdi(sdi),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .rng_byte(rng_byte),
        .mem_req(mem_req), .mem_grant(mem_grant), .locked(locked),
        .busy(busy), .key(key), .vec_erase(vec_erase),
        .fill_we(fill_we), .fill_addr(fill_addr)
    );

    always #2 clk = ~clk;

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 190000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual cycles %0d expected below 190000", cyc);
            report();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] op);
        cmd_valid = 1'b1;
        cmd_op    = op;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_op    = 2'b00;
    endtask

    // Drives 8 random bytes, one per cycle; returns the key the block must hold.
    task automatic load_key(output logic [63:0] exp);
        exp = '0;
        for (int b = 0; b < 8; b++) begin
            rng_byte = 8'($urandom);
            exp      = {exp[55:0], rng_byte};
            @(negedge clk);
        end
    endtask

    // Entered at the negedge showing the wipe strobe; ends with the new key checked.
    task automatic fill_watch(input bit inject);
        int bad_seq  = 0;
        int bad_lock = 0;
        int first_bad = -1;
        logic [63:0] exp;
        for (int i = 0; i < FILL_N; i++) begin
            @(negedge clk);
            cmd_valid = 1'b0;
            if (inject && i == 5)  begin cmd_valid = 1'b1; cmd_op = 2'b01; end
            if (inject && i == 9)  begin cmd_valid = 1'b1; cmd_op = 2'b11; end
            if (inject && i == 13) begin cmd_valid = 1'b1; cmd_op = 2'b10; end
            if (!(fill_we && fill_addr == 15'(i)) || (i == 0 && vec_erase)) begin
                bad_seq++;
                if (first_bad < 0) first_bad = i;
            end
            if (locked || mem_grant || !busy) bad_lock++;
        end
        cmd_valid = 1'b0;
        chk(bad_seq == 0, "R6 fill address sweep, first bad index", 64'(first_bad), 64'hFFFF_FFFF_FFFF_FFFF);
        chk(bad_lock == 0, "R10/R11 lock or grant seen during sequence", 64'(bad_lock), 0);
        @(negedge clk);
        chk(!fill_we && busy, "R6 fill stops after 0x7FFF", {62'd0, fill_we, busy}, 64'd1);
        load_key(exp);
        chk(key == exp, "R7 key from random bytes after fill", key, exp);
        chk(!busy, "R7 busy falls after key load", 64'(busy), 0);
    endtask

    task automatic wait_erase(output bit found);
        found = 1'b0;
        for (int i = 0; i < 400; i++) begin
            if (vec_erase) begin
                found = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        logic [63:0] exp, held;
        bit found;
        int bad;
        void'($urandom(32'h51C0_0DE5));
        rst = 1'b1; prog_n = 1'b1; sdi = 1'b0; cmd_valid = 1'b0;
        cmd_op = 2'b00; rng_byte = 8'h00; mem_req = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        mem_req = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!locked && !busy && !vec_erase && !fill_we, "R1 idle flags after reset",
            {60'd0, locked, busy, vec_erase, fill_we}, 0);
        chk(key == '0, "R1 key zero after reset", key, 0);
        chk(!mem_grant, "R1 no grant outside loader mode", 64'(mem_grant), 0);

        // R2 short low spell is ignored, R3 commands ignored outside loader mode
        prog_n = 1'b0;
        repeat (30) @(negedge clk);
        prog_n = 1'b1;
        repeat (60) @(negedge clk);
        chk(!mem_grant, "R2 30-cycle low spell ignored", 64'(mem_grant), 0);
        send(2'b01);
        @(negedge clk);
        chk(!locked, "R3 lock ignored outside loader mode", 64'(locked), 0);

        // R2 long low spell enters loader mode
        prog_n = 1'b0;
        repeat (40) @(negedge clk);
        chk(!mem_grant, "R2 not in loader mode after 40 low cycles", 64'(mem_grant), 0);
        repeat (60) @(negedge clk);
        chk(mem_grant, "R2 loader mode after 100 low cycles", 64'(mem_grant), 1);
        prog_n = 1'b1;
        repeat (20) @(negedge clk);
        chk(mem_grant, "R2 20-cycle high spell keeps loader mode", 64'(mem_grant), 1);
        prog_n = 1'b0;
        repeat (10) @(negedge clk);

        // R8 fresh key while unlocked
        send(2'b11);
        chk(busy, "R10 busy during key load", 64'(busy), 1);
        load_key(exp);
        chk(key == exp && !busy, "R8 fresh key loaded", key, exp);

        // R4 grant follows request when unlocked and idle
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            mem_req = 1'($urandom);
            #1;
            if (mem_grant != mem_req) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R4 grant follows request while unlocked", 64'(bad), 0);

        // R5..R7, R10, R11 unlock with commands injected during the fill
        mem_req = 1'b1;
        held = key;
        send(2'b10);
        chk(vec_erase && busy && !locked, "R5 wipe strobe after unlock",
            {61'd0, vec_erase, busy, locked}, 64'd6);
        chk(key == '0 && held != '0, "R5 key wiped", key, 0);
        fill_watch(1'b1);

        // R3 lock, R4 refusal, R8 fresh key refused while locked
        send(2'b01);
        chk(locked, "R3 lock command sets lock", 64'(locked), 1);
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            mem_req = 1'($urandom);
            #1;
            if (mem_grant) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R4 grant refused while locked", 64'(bad), 0);
        held = key;
        send(2'b11);
        repeat (12) begin
            rng_byte = 8'($urandom);
            @(negedge clk);
        end
        chk(key == held && !busy, "R8 fresh key ignored while locked", key, held);

        // R3 unlock ignored outside loader mode
        prog_n = 1'b1;
        repeat (100) @(negedge clk);
        send(2'b10);
        repeat (5) @(negedge clk);
        chk(locked && !busy, "R3 unlock ignored outside loader mode", {62'd0, locked, busy}, 64'd2);

        // R9 short self-destruct pulses rejected
        for (int p = 0; p < 10; p++) begin
            int len = 1 + int'($urandom % 20);
            sdi = 1'b1;
            repeat (len) @(negedge clk);
            sdi = 1'b0;
            repeat (30) @(negedge clk);
        end
        repeat (30) @(negedge clk);
        chk(locked && !busy && key == held, "R9 short pulses rejected", {62'd0, locked, busy}, 64'd2);

        // R9 long pulse wipes outside loader mode
        sdi = 1'b1;
        fork
            begin
                repeat (60) @(negedge clk);
                sdi = 1'b0;
            end
        join_none
        wait_erase(found);
        chk(found, "R9 60-cycle pulse starts wipe", 64'(found), 1);
        if (found) begin
            chk(key == '0 && !locked, "R5 tamper wipe clears key and lock", key, 0);
            fill_watch(1'b0);
        end

        report();
        $finish;
    end
endmodule